// File: doc/BRIEF.md
# Dual-Request ADC Trigger Arbiter

This block sits in front of a single analog-to-digital converter. The converter is shared by two conversion requests, a primary one and a secondary one. A request is started either by a software start pulse or by a rising edge on a shared, asynchronous hardware trigger pin. Each request has arm, trigger-mask and one-shot controls. A global trigger-ignore bit and a global enable gate all incoming events. The block decides which request converts next. It holds back or discards triggers that arrive while the converter is busy. It raises a separately maskable done interrupt for each request.

The converter is reached through a one-cycle start strobe that carries a request ID, and a one-cycle done strobe comes back from it. The block does not care how long a conversion lasts. Register access, channel selection and result storage belong to the surrounding logic.

Top module: `adc_trig_arbiter`

## Requirements
- R1: After reset, `conv_start` is 0 and both `irq` bits are 0.
- R2: A `sw_start[i]` pulse with `enable` high produces exactly one `conv_start` pulse with `conv_id` equal to i. Index and ID 0 are the primary request and 1 is the secondary. The matching `conv_done` sets the done flag of request i. The flag stays set until `irq_clr[i]` is pulsed.
- R3: `irq[i]` is high exactly when the done flag of request i is set and `irq_mask[i]` is 0. A flag that is masked is kept, and it shows up on `irq[i]` once the mask is cleared.
- R4: A rising edge on `hw_trig` passes through a two-flop synchronizer and then starts a conversion for every request whose `hw_arm` bit is 1.
- R5: A hardware trigger for request i that arrives while the other request is converting is discarded if `trig_mask[i]` is 1.
- R6: If `trig_mask[i]` is 0, that hardware trigger is held, and request i is started after the current conversion's done strobe.
- R7: A hardware trigger or software start for a request that is already converting is not stored.
- R8: A request that becomes pending in an earlier cycle is converted before one that becomes pending later.
- R9: When both requests become pending in the same cycle, the primary goes first if the two `trig_mask` bits are equal. Otherwise the request whose `trig_mask` bit is 1 goes first.
- R10: While `one_shot[i]` is 1, only the first accepted hardware trigger of request i is taken. Later ones are refused until `one_shot[i]` returns to 0.
- R11: Software start pulses are not affected by `trig_mask` or `one_shot`.
- R12: While `trig_ignore` is 1, the hardware trigger pin starts nothing.
- R13: While `enable` is 0, neither hardware triggers nor software starts create a pending request.
- R14: `conv_start` is a single-cycle pulse and is never raised while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable for all start events |
| trig_ignore | input | 1 | Ignore the hardware trigger pin |
| hw_trig | input | 1 | Asynchronous hardware trigger pin |
| hw_arm | input | 2 | Per request: respond to the hardware trigger |
| trig_mask | input | 2 | Per request: drop hardware triggers that arrive during the other request's conversion |
| one_shot | input | 2 | Per request: accept a single hardware trigger |
| sw_start | input | 2 | Per request: software start pulse |
| irq_mask | input | 2 | Per request: interrupt mask |
| irq_clr | input | 2 | Per request: write-one-to-clear strobe for the done flag |
| conv_done | input | 1 | Converter finished (one-cycle strobe) |
| conv_start | output | 1 | Start the converter (one-cycle strobe) |
| conv_id | output | 1 | Request being converted |
| irq | output | 2 | Per-request done interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the start strobe is a single cycle and never appears during a conversion;
- a done strobe sets the flag of the request in flight;
- a disabled or trigger-ignoring block gains no pending work;
- a spent one-shot admits no hardware start.

Only the directed scenarios can show the ordering outcomes, because these depend on when events arrive. These are first-come order, the tie rule driven by the mask bits, and whether a trigger arriving mid-conversion was held or dropped. The scenarios also show that a masked interrupt is kept and later appears on the output.

// File: rtl/adc_trig_arbiter.sv
module adc_trig_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       trig_ignore,
  input  logic       hw_trig,
  input  logic [1:0] hw_arm,
  input  logic [1:0] trig_mask,
  input  logic [1:0] one_shot,
  input  logic [1:0] sw_start,
  input  logic [1:0] irq_mask,
  input  logic [1:0] irq_clr,
  input  logic       conv_done,
  output logic       conv_start,
  output logic       conv_id,
  output logic [1:0] irq
);

  logic [SYNC_STAGES:0] trig_sh;
  logic       busy;
  logic [1:0] pend, os_used, flag;
  logic [1:0] hw_take, set_hw, set_sw, grant;
  logic       hw_edge, dispatch, pick, done_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_sh <= '0;
    else        trig_sh <= {trig_sh[SYNC_STAGES-1:0], hw_trig};
  end

  assign hw_edge  = trig_sh[SYNC_STAGES-1] & ~trig_sh[SYNC_STAGES];
  assign done_ev  = busy & conv_done;
  assign dispatch = ~busy & |pend;
  assign pick     = (pend == 2'b11) ? ((trig_mask[0] != trig_mask[1]) ? trig_mask[1] : 1'b0)
                                    : pend[1];
  assign grant    = dispatch ? (pick ? 2'b10 : 2'b01) : 2'b00;

  for (genvar i = 0; i < 2; i++) begin : g_req
    logic self_busy;
    assign self_busy  = busy & (conv_id == 1'(i));
    assign hw_take[i] = hw_edge & enable & ~trig_ignore & hw_arm[i] & ~os_used[i];
    assign set_hw[i]  = hw_take[i] & ~self_busy & ~(busy & trig_mask[i]);
    assign set_sw[i]  = enable & sw_start[i] & ~self_busy;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        os_used[i] <= 1'b0;
        pend[i]    <= 1'b0;
        flag[i]    <= 1'b0;
      end else begin
        if (!one_shot[i])   os_used[i] <= 1'b0;
        else if (set_hw[i]) os_used[i] <= 1'b1;
        pend[i] <= (pend[i] & ~grant[i]) | set_hw[i] | set_sw[i];
        flag[i] <= (flag[i] & ~irq_clr[i]) | (done_ev & (conv_id == 1'(i)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_id    <= 1'b0;
    end else begin
      conv_start <= dispatch;
      if (dispatch) begin
        busy    <= 1'b1;
        conv_id <= pick;
      end else if (done_ev) begin
        busy <= 1'b0;
      end
    end
  end

  assign irq = flag & ~irq_mask;

  // R14
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R14
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_start);
  // R2
  flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && conv_id == 1'b0) |=> flag[0]);
  // R2
  flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && conv_id == 1'b1) |=> flag[1]);
  // R13
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && pend == 2'b00) |=> pend == 2'b00);
  // R12
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ignore && sw_start == 2'b00 && pend == 2'b00) |=> pend == 2'b00);
  // R10
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_used[0] && one_shot[0] && !sw_start[0] && !pend[0]) |=> !pend[0]);

endmodule

// File: tb/test_adc_trig_arbiter.sv
module test_adc_trig_arbiter;
  logic clk = 0, rst_n = 0;
  logic enable = 0, trig_ignore = 0, hw_trig = 0;
  logic [1:0] hw_arm = 0, trig_mask = 0, one_shot = 0, sw_start = 0, irq_mask = 0, irq_clr = 0;
  logic conv_done = 0;
  logic conv_start, conv_id;
  logic [1:0] irq;

  int n_chk = 0, n_fail = 0;
  int starts = 0, overlaps = 0, cnt = 0;
  logic id_log [64];

  always #5 clk = ~clk;

  adc_trig_arbiter i_adc_trig_arbiter (
    .clk, .rst_n, .enable, .trig_ignore, .hw_trig, .hw_arm, .trig_mask, .one_shot,
    .sw_start, .irq_mask, .irq_clr, .conv_done, .conv_start, .conv_id, .irq);

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      if (cnt != 0) overlaps <= overlaps + 1;
      cnt <= 16;
      id_log[starts[5:0]] <= conv_id;
      starts <= starts + 1;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) conv_done <= 1'b1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw(int i);
    @(negedge clk); sw_start[i] = 1'b1;
    @(negedge clk); sw_start = 2'b00;
  endtask

  task automatic hw_pulse();
    @(negedge clk); hw_trig = 1'b1;
    cyc(4); hw_trig = 1'b0;
  endtask

  task automatic clean();
    cyc(2);
    irq_clr = 2'b11; cyc(1); irq_clr = 2'b00;
    hw_arm = 0; trig_mask = 0; one_shot = 0; irq_mask = 0; trig_ignore = 0; enable = 1;
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_sw_basic();
    int b;
    clean(); b = starts;
    sw(0); cyc(30);
    chk("R2 starts", starts - b, 1);
    chk("R2 id", id_log[b[5:0]], 0);
    chk("R2 irq", irq, 2'b01);
    cyc(5);
    chk("R2 flag held", irq, 2'b01);
    irq_clr = 2'b01; cyc(1); irq_clr = 0; cyc(1);
    chk("R2 cleared", irq, 0);
  endtask

  task automatic t_irq_mask();
    int b;
    clean(); b = starts;
    irq_mask = 2'b10;
    sw(1); cyc(30);
    chk("R3 masked irq", irq, 0);
    chk("R3 id", id_log[b[5:0]], 1);
    irq_mask = 0; cyc(1);
    chk("R3 unmasked irq", irq, 2'b10);
  endtask

  task automatic t_hw_same_mask();
    int b;
    clean(); b = starts;
    hw_arm = 2'b11; trig_mask = 2'b00;
    hw_pulse(); cyc(70);
    chk("R4 starts", starts - b, 2);
    chk("R9 first primary", id_log[b[5:0]], 0);
    chk("R9 second", id_log[6'(b + 1)], 1);
    chk("R14 overlap", overlaps, 0);
  endtask

  task automatic t_hw_diff_mask();
    int b;
    clean(); b = starts;
    hw_arm = 2'b11; trig_mask = 2'b10;
    hw_pulse(); cyc(70);
    chk("R9 starts", starts - b, 2);
    chk("R9 masked first", id_log[b[5:0]], 1);
    chk("R9 then primary", id_log[6'(b + 1)], 0);
  endtask

  task automatic t_drop();
    int b;
    clean(); b = starts;
    hw_arm = 2'b10; trig_mask = 2'b10;
    sw(0); cyc(3); hw_pulse(); cyc(60);
    chk("R5 starts", starts - b, 1);
    chk("R5 id", id_log[b[5:0]], 0);
  endtask

  task automatic t_hold();
    int b;
    clean(); b = starts;
    hw_arm = 2'b10; trig_mask = 2'b00;
    sw(0); cyc(3); hw_pulse(); cyc(60);
    chk("R6 starts", starts - b, 2);
    chk("R6 order", id_log[6'(b + 1)], 1);
  endtask

  task automatic t_self();
    int b;
    clean(); b = starts;
    hw_arm = 2'b01;
    sw(0); cyc(3); sw(0); hw_pulse(); cyc(60);
    chk("R7 starts", starts - b, 1);
  endtask

  task automatic t_first_come();
    int b;
    clean(); b = starts;
    @(negedge clk); sw_start = 2'b10;
    @(negedge clk); sw_start = 2'b01;
    @(negedge clk); sw_start = 2'b00;
    cyc(60);
    chk("R8 starts", starts - b, 2);
    chk("R8 first", id_log[b[5:0]], 1);
    chk("R8 second", id_log[6'(b + 1)], 0);
  endtask

  task automatic t_sw_mask();
    int b;
    clean(); b = starts;
    trig_mask = 2'b11; one_shot = 2'b11;
    sw(0); cyc(3); sw(1); cyc(60);
    chk("R11 starts", starts - b, 2);
  endtask

  task automatic t_oneshot();
    int b;
    clean(); b = starts;
    hw_arm = 2'b01; one_shot = 2'b01;
    hw_pulse(); cyc(30);
    chk("R10 first hw", starts - b, 1);
    hw_pulse(); cyc(30);
    chk("R10 refused", starts - b, 1);
    sw(0); cyc(30);
    chk("R11 sw with one-shot", starts - b, 2);
    one_shot = 0; cyc(2);
    hw_pulse(); cyc(30);
    chk("R10 rearmed", starts - b, 3);
  endtask

  task automatic t_ignore();
    int b;
    clean(); b = starts;
    hw_arm = 2'b11; trig_ignore = 1;
    hw_pulse(); cyc(40);
    chk("R12 starts", starts - b, 0);
  endtask

  task automatic t_disable();
    int b;
    clean(); b = starts;
    hw_arm = 2'b11; enable = 0;
    sw(0); sw(1); hw_pulse(); cyc(40);
    chk("R13 starts", starts - b, 0);
    chk("R13 irq", irq, 0);
    enable = 1;
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1;
        t_reset();
        t_sw_basic();
        t_irq_mask();
        t_hw_same_mask();
        t_hw_diff_mask();
        t_drop();
        t_hold();
        t_self();
        t_first_come();
        t_sw_mask();
        t_oneshot();
        t_ignore();
        t_disable();
        chk("R14 no overlap", overlaps, 0);
      end
      begin
        cyc(20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule